// File: doc/BRIEF.md
# Burst-of-two SRAM with separate read and write ports

This block is an on-chip memory with one read port and one write port that share a single address bus. The bus is used in alternate word slots. Every access moves two 18-bit words, A+0 then A+1, that belong to one address location. A single clock runs at the word rate, so every rising edge of `clk` is a word slot. Slots alternate between a K slot and a K# slot. The first rising edge at which `rst_n` is sampled high is a K slot.

A read is requested in a K slot, and the address on the bus in that slot is the read address. A write is requested in a K slot together with its first data word and that word's lane mask. The write address, the second data word and the second mask follow in the next K# slot. Write masking works on two 9-bit lanes, and each word of a burst carries its own mask. Read data comes out as a registered two-word burst, marked by `dout_en`. While `dout_en` is low, `dout` is zero. A synchronous reset empties the pipelines and leaves the stored words as they were.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset, `dout_en` is 0 and `dout` is zero. The first rising edge with `rst_n` sampled high is a K slot, and the slot kind alternates on every edge after that.
- R2: A read is requested when `rd_sel_n` is low at a K slot edge. The `addr` value sampled at that edge is the read location A.
- R3: If a read is requested at edge e, word A+0 is on `dout` with `dout_en` high after edge e+2, and word A+1 is there after edge e+3.
- R4: A write is requested when `wr_sel_n` is low at a K slot edge. `din` and `bw_n` at that edge are word A+0 and its mask. At the next edge (a K# slot), `addr` is the write location, and `din` and `bw_n` are word A+1 and its mask.
- R5: `bw_n[0]` low writes bits 8:0 and `bw_n[1]` low writes bits 17:9. A lane whose bit is high keeps its stored value.
- R6: The two words of one write burst use independent masks, so any of the 16 mask pairs is honoured.
- R7: When `rd_sel_n` is high in a K slot, that slot starts no output: `dout_en` stays 0 and `dout` stays zero unless an earlier burst is still due. When `wr_sel_n` is high in a K slot, no stored word changes.
- R8: A read and a write requested in the same K slot to the same location return the previously stored words. A read requested in the next K slot returns the new words.
- R9: Reads requested in consecutive K slots produce an unbroken stream of output words with `dout_en` held high.
- R10: With `rst_n` low at an edge, `dout_en` is 0 after that edge, and a read in flight is dropped. Stored words survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock; edges alternate K and K# slots |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Shared address: read location in K slots, write location in K# slots |
| rd_sel_n | input | 1 | Active-low read request, sampled in K slots |
| wr_sel_n | input | 1 | Active-low write request, sampled in K slots |
| bw_n | input | 2 | Active-low lane write enables for the word in the current slot |
| din | input | 18 | Write data word for the current slot |
| dout | output | 18 | Read data word; zero when `dout_en` is low |
| dout_en | output | 1 | High while `dout` carries a read word |

## Verification
A read requested at K slot edge e has its first word due after edge e+2 and its second after edge e+3. A write takes effect at the K# edge that follows its request, which is early enough for a read requested in the next K slot. The bench numbers the edges from the release of reset. When it issues a read, it files the two expected words in a small ring indexed by edge number, and it compares the outputs at every falling edge against that ring entry. Each read expectation is taken from the bench's own memory image before the same slot's write is applied to that image, so the same-slot read-before-write order is checked directly.

// File: rtl/qdr_b2_pkg.sv
// Shared constants and types for the burst-of-two SRAM.
// Assumes a word of two equal lanes, each with its own write enable.
package qdr_b2_pkg;
    localparam int WORD_W = 18;
    localparam int LANES  = 2;
    localparam int LANE_W = WORD_W / LANES;
    localparam int BURST  = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BURST-1:0][WORD_W-1:0] burst_t;
    typedef logic [BURST-1:0][LANES-1:0] burst_mask_t;
endpackage

// File: rtl/qdr_b2_wcap.sv
// Write capture: holds the first word and its lane mask from the K slot,
// then presents the complete burst for commit in the following K# slot.
// Assumes kbar_slot is high exactly when the coming edge is a K# slot.
module qdr_b2_wcap
    import qdr_b2_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbar_slot,
    input  logic              wr_sel_n,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  bw_n,
    input  word_t             din,
    output logic              commit,
    output logic [AW-1:0]     commit_addr,
    output burst_t            commit_data,
    output burst_mask_t       commit_mask
);
    logic             pend_q;
    word_t            first_q;
    logic [LANES-1:0] first_en_q;

    // Capture the request, word A+0 and its lane enables in the K slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            first_q    <= '0;
            first_en_q <= '0;
        end else if (!kbar_slot) begin
            pend_q     <= ~wr_sel_n;
            first_q    <= din;
            first_en_q <= ~bw_n;
        end
    end

    // Assemble the full burst from the held word and the K# slot inputs.
    always_comb begin
        commit         = pend_q & kbar_slot;
        commit_addr    = addr;
        commit_data[0] = first_q;
        commit_data[1] = din;
        commit_mask[0] = first_en_q;
        commit_mask[1] = ~bw_n;
    end
endmodule

// File: rtl/qdr_b2_array.sv
// Storage: one bank per burst position, each split into lanes with
// separate write enables. Writes on the clock; reads are combinational.
// Assumes no reset of contents; unwritten locations read as unknown.
module qdr_b2_array
    import qdr_b2_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic         clk,
    input  logic         we,
    input  logic [AW-1:0] waddr,
    input  burst_t       wdata,
    input  burst_mask_t  wlane,
    input  logic [AW-1:0] raddr,
    output burst_t       rdata
);
    for (genvar b = 0; b < BURST; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            // Store one lane of one burst word when its enable is set.
            always_ff @(posedge clk) begin
                if (we && wlane[b][l]) begin
                    mem[waddr] <= wdata[b][l*LANE_W +: LANE_W];
                end
            end

            assign rdata[b][l*LANE_W +: LANE_W] = mem[raddr];
        end
    end
endmodule

// File: rtl/qdr_b2_rpipe.sv
// Read pipeline: latches the read location in a K slot, snapshots both
// words at the K# edge, then emits A+0 and A+1 on the next two edges.
// Assumes rdata is the combinational array read at raddr.
module qdr_b2_rpipe
    import qdr_b2_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kbar_slot,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] addr,
    input  burst_t        rdata,
    output logic [AW-1:0] raddr,
    output word_t         dout,
    output logic          dout_en
);
    logic   req_q;
    burst_t held_q;
    logic   held_v_q;
    logic   hi_due_q;

    // Capture a read request and its location in the K slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            raddr <= '0;
        end else if (!kbar_slot) begin
            req_q <= ~rd_sel_n;
            if (!rd_sel_n) begin
                raddr <= addr;
            end
        end
    end

    // Snapshot both words at the K# edge, before that edge's write lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v_q <= 1'b0;
            held_q   <= '0;
        end else if (kbar_slot) begin
            held_v_q <= req_q;
            held_q   <= rdata;
        end
    end

    // Drive word A+0 at the K edge and word A+1 at the following K# edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_en  <= 1'b0;
            hi_due_q <= 1'b0;
        end else if (!kbar_slot) begin
            dout     <= held_v_q ? held_q[0] : '0;
            dout_en  <= held_v_q;
            hi_due_q <= held_v_q;
        end else begin
            dout     <= hi_due_q ? held_q[1] : '0;
            dout_en  <= hi_due_q;
        end
    end

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);
    assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbar_slot && !rd_sel_n) |=> ##2 dout_en);
    assert_second_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbar_slot && !rd_sel_n) |=> ##3 dout_en);
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> !dout_en);
endmodule

// File: rtl/qdr_b2_sram.sv
// Top: burst-of-two SRAM with separate read and write ports on one
// shared address bus. Owns the K / K# slot tracker and joins the write
// capture, the read pipeline and the storage.
// Assumes the first edge with rst_n sampled high is a K slot.
module qdr_b2_sram
    import qdr_b2_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    logic          kbar_slot;
    logic          commit;
    logic [AW-1:0] commit_addr;
    burst_t        commit_data;
    burst_mask_t   commit_mask;
    logic [AW-1:0] raddr;
    burst_t        rdata;

    // Track which slot the coming edge is: 0 for K, 1 for K#.
    always_ff @(posedge clk) begin
        if (!rst_n) kbar_slot <= 1'b0;
        else        kbar_slot <= ~kbar_slot;
    end

    qdr_b2_wcap #(.AW(AW)) u_wcap (
        .clk         (clk),
        .rst_n       (rst_n),
        .kbar_slot   (kbar_slot),
        .wr_sel_n    (wr_sel_n),
        .addr        (addr),
        .bw_n        (bw_n),
        .din         (din),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .commit_mask (commit_mask)
    );

    qdr_b2_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (commit_addr),
        .wdata (commit_data),
        .wlane (commit_mask),
        .raddr (raddr),
        .rdata (rdata)
    );

    qdr_b2_rpipe #(.AW(AW)) u_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbar_slot (kbar_slot),
        .rd_sel_n  (rd_sel_n),
        .addr      (addr),
        .rdata     (rdata),
        .raddr     (raddr),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    assert_commit_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(!wr_sel_n) && !$past(kbar_slot)));
    assert_req_leads_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbar_slot && !wr_sel_n) |=> commit);
    assert_slots_alternate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        kbar_slot |=> !kbar_slot);
endmodule

// File: tb/tb_qdr_b2_sram.sv
// Self-checking bench: full writes, a sweep of all mask pairs on every
// location, deselected slots, same-slot read/write and reset mid-burst.
module tb_qdr_b2_sram;
    localparam int D  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          rd_sel_n, wr_sel_n;
    logic [1:0]    bw_n;
    logic [17:0]   din;
    logic [17:0]   dout;
    logic          dout_en;

    always #4 clk = ~clk;

    qdr_b2_sram #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .bw_n(bw_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    int          checks = 0;
    int          fails  = 0;
    int          ec     = 0;
    logic [17:0] mm   [0:2*D-1];
    logic        ex_en  [0:7];
    logic [17:0] ex_d   [0:7];
    string       ex_tag [0:7];

    function automatic logic [17:0] merge(logic [17:0] old_w, logic [17:0] new_w, logic [1:0] m);
        logic [17:0] r = old_w;
        if (!m[0]) r[8:0]  = new_w[8:0];
        if (!m[1]) r[17:9] = new_w[17:9];
        return r;
    endfunction

    task automatic clear_ring();
        for (int i = 0; i < 8; i++) begin
            ex_en[i] = 1'b0; ex_d[i] = '0; ex_tag[i] = "R7";
        end
    endtask

    task automatic check_now();
        int i = ec % 8;
        checks++;
        if (dout_en !== ex_en[i] || dout !== ex_d[i]) begin
            fails++;
            $display("FAIL %s edge %0d: got en=%0b dout=%h, expected en=%0b dout=%h",
                     ex_tag[i], ec, dout_en, dout, ex_en[i], ex_d[i]);
        end
        ex_en[i] = 1'b0; ex_d[i] = '0; ex_tag[i] = "R7";
    endtask

    // One edge: drive at a falling edge, pass the rising edge, check.
    task automatic edge_drive(logic rsn, logic wsn, int a, logic [17:0] d, logic [1:0] m);
        rd_sel_n = rsn; wr_sel_n = wsn; addr = AW'(a); din = d; bw_n = m;
        @(posedge clk);
        ec++;
        @(negedge clk);
        check_now();
    endtask

    // One K + K# pair; the read expectation is taken before this slot's write.
    task automatic step(bit rd, int ra, bit wr, int wa,
                        logic [17:0] d0, logic [1:0] m0,
                        logic [17:0] d1, logic [1:0] m1, string tag);
        int e = ec;
        if (rd) begin
            ex_en[(e+3)%8] = 1'b1; ex_d[(e+3)%8] = mm[ra*2];   ex_tag[(e+3)%8] = tag;
            ex_en[(e+4)%8] = 1'b1; ex_d[(e+4)%8] = mm[ra*2+1]; ex_tag[(e+4)%8] = tag;
        end
        edge_drive(!rd, !wr, ra, d0, m0);
        if (wr) begin
            mm[wa*2]   = merge(mm[wa*2],   d0, m0);
            mm[wa*2+1] = merge(mm[wa*2+1], d1, m1);
        end
        edge_drive(1'b1, 1'b1, wa, d1, m1);
    endtask

    task automatic do_reset(string tag);
        rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (dout_en !== 1'b0 || dout !== '0) begin
                fails++;
                $display("FAIL %s reset: got en=%0b dout=%h, expected en=0 dout=00000",
                         tag, dout_en, dout);
            end
        end
        rst_n = 1'b1;
        clear_ring();
        ec = 0;
    endtask

    function automatic logic [17:0] pat(int a, int w, int s);
        return 18'(a * 4111 + w * 26219 + s * 7919 + 5);
    endfunction

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        addr = '0; din = '0; bw_n = 2'b11;
        clear_ring();
        @(negedge clk);
        do_reset("R1");

        // R4: full-mask writes to every location, then R2 R3 R9 back-to-back reads.
        for (int a = 0; a < D; a++)
            step(0, 0, 1, a, pat(a, 0, 1), 2'b00, pat(a, 1, 1), 2'b00, "R4");
        for (int a = 0; a < D; a++)
            step(1, a, 0, 0, '0, 2'b11, '0, 2'b11, "R2/R3/R9/R4");
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");

        // R5 R6: every mask pair on every location, read back in the next slot.
        for (int a = 0; a < D; a++) begin
            for (int c = 0; c < 16; c++) begin
                step(0, 0, 1, a, pat(a, 0, c + 2), 2'(c), pat(a, 1, c + 2), 2'(c >> 2), "R5");
                step(1, a, 0, 0, '0, 2'b11, '0, 2'b11, "R5/R6");
            end
        end

        // R7: deselected slots with busy buses change nothing and emit nothing.
        for (int a = 0; a < D; a++)
            step(0, a, 0, a, 18'h3ffff, 2'b00, 18'h2aaaa, 2'b00, "R7");
        for (int a = 0; a < D; a++)
            step(1, a, 0, 0, '0, 2'b11, '0, 2'b11, "R7");
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");

        // R8: same-slot read and write to one location return old words.
        for (int a = 0; a < D; a += 5) begin
            step(1, a, 1, a, pat(a, 0, 40), 2'b00, pat(a, 1, 40), 2'b00, "R8");
            step(1, a, 0, 0, '0, 2'b11, '0, 2'b11, "R8");
        end
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");

        // R10: reset during a read drops it and keeps stored words.
        step(1, 3, 0, 0, '0, 2'b11, '0, 2'b11, "R10");
        do_reset("R10");
        step(1, 3, 0, 0, '0, 2'b11, '0, 2'b11, "R10");
        step(1, 9, 0, 0, '0, 2'b11, '0, 2'b11, "R10");
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");
        step(0, 0, 0, 0, '0, 2'b11, '0, 2'b11, "R7");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule